// File: doc/BRIEF.md
# Single-Cycle Six-Instruction Processor Core

This block is a small processor core that fetches, decodes and retires one 32-bit instruction on every rising clock edge. It holds the program counter, a word-addressed instruction store, a 32-entry by 32-bit register file, an immediate extender, a three-function ALU, a word-addressed data store and a combinational decoder. It runs six operations: unsigned register add, unsigned register subtract, OR with a zero-extended immediate, word load, word store and branch-if-equal. Every other encoding retires as a no-op.

Before a program runs, a test harness fills both stores through a load port. While that port is active the core is frozen. Debug outputs show the current PC and the register write the current instruction commits at the next edge, so the program can be traced from outside the core.

Top module: `ml_core`

## Requirements
- R1: While `rst_n` is low at a rising edge, the PC is cleared to 0. While `rst_n` is low, `dbg_wb_en` is 0.
- R2: An R-format word (op[31:26]=0x00) with funct[5:0]=0x21 writes R[rs]+R[rt] into R[rd], and with funct 0x23 writes R[rs]-R[rt], both modulo 2^32. The fields are rs=[25:21], rt=[20:16] and rd=[15:11]. The PC then advances by 4.
- R3: op 0x0D writes R[rs] OR {16'h0000, imm[15:0]} into R[rt]. The upper half of the immediate is always zero.
- R4: op 0x23 loads the data word at index (R[rs]+sign_extend(imm))[9:2] into R[rt]. op 0x2B stores R[rt] to the word at that same index.
- R5: op 0x04 with R[rs]==R[rt] sets the PC to PC + (sign_extend(imm) << 2). Otherwise it sets the PC to PC+4.
- R6: Register 0 always reads as zero. A write aimed at it is discarded.
- R7: An instruction whose destination is also one of its sources reads the old value. The new value is visible to the next instruction.
- R8: Any other opcode, and any R-format funct other than 0x21 or 0x23, writes no register or memory and advances the PC by 4.
- R9: Reset clears all 32 registers. Data memory contents survive reset.
- R10: While `ld_en` is 1, the PC holds and the core commits no register or data write. The load port writes `ld_data` into the instruction store (`ld_sel`=0) or the data store (`ld_sel`=1) at word `ld_addr`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge active |
| rst_n | input | 1 | Synchronous active-low reset |
| ld_en | input | 1 | Load port write strobe; also freezes the core |
| ld_sel | input | 1 | Load target: 0 instruction store, 1 data store |
| ld_addr | input | 8 | Word index for the load port |
| ld_data | input | 32 | Word to be loaded |
| dbg_pc | output | 32 | Current program counter |
| dbg_wb_en | output | 1 | Register write commits at the next edge |
| dbg_wb_addr | output | 5 | Destination register of that write |
| dbg_wb_data | output | 32 | Value of that write |

## Verification
Two functions can fall in the same cycle: reading a register's old value as an operand, and overwriting that same register with the result. The bench provokes this with an add whose destination equals both sources, and with a load whose base register is also its target. A bench-side instruction model predicts each retired instruction from the old register state, and the monitor compares the debug write value in that cycle. It also checks that the following instruction sees the new value.

// File: rtl/ml_pkg.sv
// Package: shared constants, opcode/funct encodings and the decoded control bundle.
// Assumes a 32-bit word and a 5-bit register index throughout.
package ml_pkg;
    localparam int XLEN   = 32;
    localparam int RIDX_W = 5;
    localparam int NREGS  = 1 << RIDX_W;

    localparam logic [5:0] OP_RTYPE = 6'h00;
    localparam logic [5:0] OP_ORI   = 6'h0D;
    localparam logic [5:0] OP_LOAD  = 6'h23;
    localparam logic [5:0] OP_STORE = 6'h2B;
    localparam logic [5:0] OP_BEQ   = 6'h04;
    localparam logic [5:0] FN_ADDU  = 6'h21;
    localparam logic [5:0] FN_SUBU  = 6'h23;

    typedef enum logic [1:0] {ALU_ADD, ALU_SUB, ALU_OR} alu_fn_e;

    typedef struct packed {
        logic    reg_wr;
        logic    dst_is_rd;
        logic    b_is_imm;
        logic    imm_zero;
        logic    mem_wr;
        logic    wb_from_mem;
        logic    is_branch;
        alu_fn_e alu_fn;
    } ctrl_t;
endpackage

// File: rtl/ml_decoder.sv
// Decoder: maps opcode and funct to the control bundle.
// Assumes unknown encodings must act as no-ops, so every control defaults to inactive.
module ml_decoder
    import ml_pkg::*;
(
    input  logic [5:0] op,
    input  logic [5:0] funct,
    output ctrl_t      ctrl
);
    // Purpose: pick control settings for the six supported operations.
    always_comb begin
        ctrl = '{default: '0, alu_fn: ALU_ADD};
        unique case (op)
            OP_RTYPE: begin
                if (funct == FN_ADDU || funct == FN_SUBU) begin
                    ctrl.reg_wr    = 1'b1;
                    ctrl.dst_is_rd = 1'b1;
                    ctrl.alu_fn    = (funct == FN_SUBU) ? ALU_SUB : ALU_ADD;
                end
            end
            OP_ORI: begin
                ctrl.reg_wr   = 1'b1;
                ctrl.b_is_imm = 1'b1;
                ctrl.imm_zero = 1'b1;
                ctrl.alu_fn   = ALU_OR;
            end
            OP_LOAD: begin
                ctrl.reg_wr      = 1'b1;
                ctrl.b_is_imm    = 1'b1;
                ctrl.wb_from_mem = 1'b1;
            end
            OP_STORE: begin
                ctrl.b_is_imm = 1'b1;
                ctrl.mem_wr   = 1'b1;
            end
            OP_BEQ: begin
                ctrl.is_branch = 1'b1;
                ctrl.alu_fn    = ALU_SUB;
            end
            default: ;
        endcase
    end
endmodule

// File: rtl/ml_regfile.sv
// Register file: two combinational read ports, one write port committed on the clock.
// Assumes entry 0 is hard zero; synchronous active-low reset clears every entry.
module ml_regfile
    import ml_pkg::*;
(
    input  logic              clk,
    input  logic              rst_n,
    input  logic              we,
    input  logic [RIDX_W-1:0] waddr,
    input  logic [XLEN-1:0]   wdata,
    input  logic [RIDX_W-1:0] raddr_a,
    input  logic [RIDX_W-1:0] raddr_b,
    output logic [XLEN-1:0]   rdata_a,
    output logic [XLEN-1:0]   rdata_b
);
    logic [XLEN-1:0] regs [NREGS];

    // Purpose: clear on reset, else commit a write to a nonzero entry.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            for (int i = 0; i < NREGS; i++) regs[i] <= '0;
        end else if (we && waddr != '0) begin
            regs[waddr] <= wdata;
        end
    end

    // Purpose: combinational reads with entry 0 forced to zero.
    always_comb begin
        rdata_a = (raddr_a == '0) ? '0 : regs[raddr_a];
        rdata_b = (raddr_b == '0) ? '0 : regs[raddr_b];
    end

    // R6/R7: a committed write to a nonzero entry lands there
    a_r6_write_lands: assert property (@(posedge clk) disable iff (!rst_n)
        (we && waddr != '0) |=> (regs[$past(waddr)] == $past(wdata)));
endmodule

// File: rtl/ml_alu.sv
// ALU: add, subtract or OR of two words, with an equality flag.
// Assumes wrap-around arithmetic; no overflow is reported.
module ml_alu
    import ml_pkg::*;
(
    input  alu_fn_e         fn,
    input  logic [XLEN-1:0] a,
    input  logic [XLEN-1:0] b,
    output logic [XLEN-1:0] y,
    output logic            eq
);
    // Purpose: select the result for the requested function.
    always_comb begin
        unique case (fn)
            ALU_SUB: y = a - b;
            ALU_OR:  y = a | b;
            default: y = a + b;
        endcase
        eq = (a == b);
    end
endmodule

// File: rtl/ml_wordmem.sv
// Word memory: combinational read, synchronous write, no reset of contents.
// Assumes the caller supplies word indexes already trimmed to the depth.
module ml_wordmem #(
    parameter int WORDS = 256,
    parameter int WIDTH = 32,
    localparam int AW   = $clog2(WORDS)
) (
    input  logic             clk,
    input  logic             we,
    input  logic [AW-1:0]    waddr,
    input  logic [WIDTH-1:0] wdata,
    input  logic [AW-1:0]    raddr,
    output logic [WIDTH-1:0] rdata
);
    logic [WIDTH-1:0] mem [WORDS];

    // Purpose: store a word when write is enabled.
    always_ff @(posedge clk) begin
        if (we) mem[waddr] <= wdata;
    end

    // Purpose: combinational read.
    assign rdata = mem[raddr];
endmodule

// File: rtl/ml_core.sv
// Core top: PC, stores, decoder, register file, extender, ALU and next-PC logic.
// Assumes the load port is only used while the program is meant to be frozen.
module ml_core
    import ml_pkg::*;
#(
    parameter int MEM_WORDS = 256
) (
    input  logic                         clk,
    input  logic                         rst_n,
    input  logic                         ld_en,
    input  logic                         ld_sel,
    input  logic [$clog2(MEM_WORDS)-1:0] ld_addr,
    input  logic [XLEN-1:0]              ld_data,
    output logic [XLEN-1:0]              dbg_pc,
    output logic                         dbg_wb_en,
    output logic [RIDX_W-1:0]            dbg_wb_addr,
    output logic [XLEN-1:0]              dbg_wb_data
);
    localparam int AW = $clog2(MEM_WORDS);

    logic [XLEN-1:0]   pc_q, pc_next, instr, imm_ext, rs_val, rt_val;
    logic [XLEN-1:0]   alu_b, alu_y, dm_rdata, wb_data;
    logic [RIDX_W-1:0] wb_addr;
    logic              alu_eq, run, take_branch;
    ctrl_t             ctrl;

    assign run = rst_n && !ld_en;

    ml_wordmem #(.WORDS(MEM_WORDS), .WIDTH(XLEN)) i_imem (
        .clk(clk), .we(ld_en && !ld_sel), .waddr(ld_addr), .wdata(ld_data),
        .raddr(pc_q[AW+1:2]), .rdata(instr));

    ml_decoder i_dec (.op(instr[31:26]), .funct(instr[5:0]), .ctrl(ctrl));

    ml_regfile i_rf (
        .clk(clk), .rst_n(rst_n), .we(run && ctrl.reg_wr),
        .waddr(wb_addr), .wdata(wb_data),
        .raddr_a(instr[25:21]), .raddr_b(instr[20:16]),
        .rdata_a(rs_val), .rdata_b(rt_val));

    // Purpose: extend the immediate, choose ALU operand B and the destination.
    always_comb begin
        imm_ext = ctrl.imm_zero ? {16'h0000, instr[15:0]} : {{16{instr[15]}}, instr[15:0]};
        alu_b   = ctrl.b_is_imm ? imm_ext : rt_val;
        wb_addr = ctrl.dst_is_rd ? instr[15:11] : instr[20:16];
    end

    ml_alu i_alu (.fn(ctrl.alu_fn), .a(rs_val), .b(alu_b), .y(alu_y), .eq(alu_eq));

    ml_wordmem #(.WORDS(MEM_WORDS), .WIDTH(XLEN)) i_dmem (
        .clk(clk),
        .we((ld_en && ld_sel) || (run && ctrl.mem_wr)),
        .waddr(ld_en ? ld_addr : alu_y[AW+1:2]),
        .wdata(ld_en ? ld_data : rt_val),
        .raddr(alu_y[AW+1:2]), .rdata(dm_rdata));

    // Purpose: pick the write-back value and the next PC.
    always_comb begin
        wb_data     = ctrl.wb_from_mem ? dm_rdata : alu_y;
        take_branch = ctrl.is_branch && alu_eq;
        pc_next     = take_branch ? pc_q + {imm_ext[XLEN-3:0], 2'b00} : pc_q + 32'd4;
    end

    // Purpose: hold the PC while loading, clear it on reset.
    always_ff @(posedge clk) begin
        if (!rst_n)    pc_q <= '0;
        else if (run)  pc_q <= pc_next;
    end

    assign dbg_pc      = pc_q;
    assign dbg_wb_en   = run && ctrl.reg_wr;
    assign dbg_wb_addr = wb_addr;
    assign dbg_wb_data = wb_data;

    // R10: the load port freezes the PC
    a_r10_hold_pc: assert property (@(posedge clk) disable iff (!rst_n)
        (rst_n && ld_en) |=> $stable(pc_q));
    // R2/R8: a non-branch retires to PC+4
    a_r2_seq_pc: assert property (@(posedge clk) disable iff (!rst_n)
        (run && !ctrl.is_branch) |=> (pc_q == $past(pc_q) + 32'd4));
    // R5: an equal compare on a branch jumps by the scaled offset
    a_r5_branch_taken: assert property (@(posedge clk) disable iff (!rst_n)
        (run && ctrl.is_branch && rs_val == rt_val) |=>
        (pc_q == $past(pc_q) + {{14{$past(instr[15])}}, $past(instr[15:0]), 2'b00}));
    // R3: the OR-immediate operand has a zero upper half
    a_r3_zero_upper: assert property (@(posedge clk) disable iff (!rst_n)
        (run && instr[31:26] == OP_ORI) |-> (alu_b[31:16] == 16'h0000));
endmodule

// File: tb/test_ml_core.sv
`timescale 1ns/100ps
// Bench: scoreboard. A driver runs an instruction model and queues the expected
// trace; a monitor pops one item per cycle and compares it with the debug outputs.
module test_ml_core;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        ld_en = 1'b0;
    logic        ld_sel = 1'b0;
    logic [7:0]  ld_addr = '0;
    logic [31:0] ld_data = '0;
    logic [31:0] dbg_pc, dbg_wb_data;
    logic        dbg_wb_en;
    logic [4:0]  dbg_wb_addr;

    int errors = 0;
    int checks = 0;
    bit running = 1'b0;

    typedef struct {
        logic [31:0] pc;
        bit          we;
        logic [4:0]  a;
        logic [31:0] d;
        string       tag;
    } exp_t;
    exp_t sb[$];

    logic [31:0] bim [256];
    logic [31:0] bdm [256];
    logic [31:0] brf [32];
    logic [31:0] bpc;
    bit          phase2 = 1'b0;

    always #2.5 clk = ~clk;

    ml_core i_ml_core (.clk(clk), .rst_n(rst_n), .ld_en(ld_en), .ld_sel(ld_sel),
        .ld_addr(ld_addr), .ld_data(ld_data), .dbg_pc(dbg_pc), .dbg_wb_en(dbg_wb_en),
        .dbg_wb_addr(dbg_wb_addr), .dbg_wb_data(dbg_wb_data));

    function automatic logic [31:0] enc_r(int rs, int rt, int rd, logic [5:0] fn);
        return {6'h00, 5'(rs), 5'(rt), 5'(rd), 5'd0, fn};
    endfunction
    function automatic logic [31:0] enc_i(logic [5:0] op, int rs, int rt, logic [15:0] imm);
        return {op, 5'(rs), 5'(rt), imm};
    endfunction

    task automatic check(bit ok, string tag, string what, logic [31:0] act, logic [31:0] exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s %s: actual=%h expected=%h", tag, what, act, exp);
        end
    endtask

    task automatic load_word(bit sel, int idx, logic [31:0] w);
        @(posedge clk); #1;
        ld_en = 1'b1; ld_sel = sel; ld_addr = 8'(idx); ld_data = w;
        if (sel) bdm[idx] = w; else bim[idx] = w;
        @(posedge clk); #1;
        ld_en = 1'b0;
    endtask

    // Model one instruction from the requirements and queue the expected item.
    task automatic model_step();
        exp_t e;
        logic [31:0] ins, sx, zx, va, vb, npc, ea;
        logic [5:0] op;
        int rs, rt, rd;
        ins = bim[bpc[9:2]];
        op = ins[31:26]; rs = ins[25:21]; rt = ins[20:16]; rd = ins[15:11];
        sx = {{16{ins[15]}}, ins[15:0]}; zx = {16'h0, ins[15:0]};
        va = brf[rs]; vb = brf[rt];
        ea = va + sx;
        e.pc = bpc; e.we = 1'b0; e.a = '0; e.d = '0; e.tag = "R8";
        npc = bpc + 32'd4;
        case (op)
            6'h00: if (ins[5:0] == 6'h21 || ins[5:0] == 6'h23) begin
                e.we = 1'b1; e.a = 5'(rd); e.tag = "R2";
                e.d = (ins[5:0] == 6'h21) ? va + vb : va - vb;
            end
            6'h0D: begin e.we = 1'b1; e.a = 5'(rt); e.d = va | zx; e.tag = "R3"; end
            6'h23: begin e.we = 1'b1; e.a = 5'(rt); e.d = bdm[ea[9:2]]; e.tag = "R4"; end
            6'h2B: begin bdm[ea[9:2]] = vb; e.tag = "R4"; end
            6'h04: begin e.tag = "R5"; if (va == vb) npc = bpc + (sx << 2); end
            default: ;
        endcase
        if (e.we && e.a == 5'd0) e.tag = "R6";
        else if (e.we && (int'(e.a) == rs || (op == 6'h00 && int'(e.a) == rt))) e.tag = "R7";
        if (phase2) e.tag = "R9";
        if (e.we && e.a != 5'd0) brf[e.a] = e.d;
        bpc = npc;
        sb.push_back(e);
    endtask

    // Monitor: compare one queued item per cycle, away from the active edge.
    always @(negedge clk) begin
        if (running && sb.size() > 0) begin
            exp_t e;
            e = sb.pop_front();
            check(dbg_pc == e.pc, e.tag, "pc", dbg_pc, e.pc);
            check(dbg_wb_en == e.we, e.tag, "wb_en", 32'(dbg_wb_en), 32'(e.we));
            if (e.we && dbg_wb_en)
                check(dbg_wb_addr == e.a && dbg_wb_data == e.d, e.tag, "wb addr/data",
                      {dbg_wb_addr, dbg_wb_data[26:0]}, {e.a, e.d[26:0]});
        end
    end

    task automatic run_model(int n);
        for (int k = 0; k < n; k++) model_step();
        running = 1'b1;
        wait (sb.size() == 0);
        @(posedge clk); #1;
        running = 1'b0;
    endtask

    task automatic do_reset();
        @(posedge clk); #1; rst_n = 1'b0;
        @(posedge clk); #1; @(posedge clk); #1;
        @(negedge clk);
        // R1: reset state at the ports
        check(dbg_pc == 32'd0, "R1", "pc in reset", dbg_pc, 32'd0);
        check(dbg_wb_en == 1'b0, "R1", "wb_en in reset", 32'(dbg_wb_en), 32'd0);
        for (int i = 0; i < 32; i++) brf[i] = '0;
        bpc = '0;
    endtask

    // Watchdog: a hang counts as one failed check and still prints the summary.
    initial begin
        repeat (20000) @(posedge clk);
        checks++; errors++;
        $display("FAIL watchdog: actual=timeout expected=completion");
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end

    initial begin
        // Program 1 loaded during reset
        load_word(0, 0,  enc_i(6'h0D, 0, 1, 16'h1234));
        load_word(0, 1,  enc_i(6'h0D, 0, 2, 16'hFFF0));
        load_word(0, 2,  enc_r(1, 2, 3, 6'h21));
        load_word(0, 3,  enc_r(1, 2, 4, 6'h23));
        load_word(0, 4,  enc_i(6'h2B, 0, 3, 16'h0008));
        load_word(0, 5,  enc_i(6'h23, 0, 5, 16'h0008));
        load_word(0, 6,  enc_i(6'h23, 7, 6, 16'hFFFC));
        load_word(0, 7,  enc_i(6'h0D, 1, 0, 16'h0005));
        load_word(0, 8,  enc_r(0, 1, 8, 6'h21));
        load_word(0, 9,  enc_i(6'h04, 1, 2, 16'h0005));
        load_word(0, 10, enc_i(6'h04, 3, 5, 16'h0002));
        load_word(0, 11, enc_i(6'h0D, 0, 9, 16'h0BAD));
        load_word(0, 12, enc_r(3, 3, 3, 6'h21));
        load_word(0, 13, enc_i(6'h23, 5, 5, 16'h0004));
        load_word(0, 14, {6'h3F, 26'h0123456});
        load_word(0, 15, enc_r(1, 1, 10, 6'h20));
        load_word(0, 16, enc_i(6'h04, 0, 0, 16'h0000));
        load_word(1, 255, 32'hCAFEF00D);
        load_word(1, 138, 32'h13579BDF);
        do_reset();

        // R10: load while running freezes PC and suppresses write-back
        @(posedge clk); #1;
        rst_n = 1'b1; ld_en = 1'b1; ld_sel = 1'b1; ld_addr = 8'd200; ld_data = 32'h00C0FFEE;
        bdm[200] = 32'h00C0FFEE;
        for (int k = 0; k < 3; k++) begin
            @(negedge clk);
            check(dbg_pc == 32'd0, "R10", "pc held during load", dbg_pc, 32'd0);
            check(dbg_wb_en == 1'b0, "R10", "wb_en during load", 32'(dbg_wb_en), 32'd0);
        end
        @(posedge clk); #1;
        ld_en = 1'b0;
        run_model(22);

        // Program 2: reset clears registers, data store survives
        phase2 = 1'b1;
        load_word(0, 0, enc_r(3, 4, 1, 6'h21));
        load_word(0, 1, enc_r(5, 8, 2, 6'h21));
        load_word(0, 2, enc_i(6'h23, 0, 6, 16'h0008));
        load_word(0, 3, enc_i(6'h23, 0, 7, 16'h0320));
        load_word(0, 4, enc_i(6'h04, 0, 0, 16'h0000));
        do_reset();
        @(posedge clk); #1; rst_n = 1'b1;
        run_model(7);

        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end
endmodule